// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block walks a ring of 8-byte buffer descriptors kept in a word-addressed memory and streams the bytes of the described buffers out of a byte-wide valid/ready stream port. A one-cycle start pulse on `tx_kick` begins a walk at the current descriptor pointer. Each descriptor that is marked ready is fetched, and its buffer is read word by word and sent byte by byte. Its ready bit is then cleared in memory, and the pointer either steps to the next descriptor or jumps back to the ring base. Buffers are joined into one frame until a descriptor marked as last is reached. Frames longer than the configured maximum are cut short.

Software fills the descriptors and sets their ready bits, then pulses `tx_kick`. It learns of progress through three single-cycle event pulses (buffer done, frame done, oversize). `tx_busy` is high for as long as a walk is in progress.

The controller runs through these named states: `S_IDLE`, `S_FETCH0`, `S_LOAD0`, `S_FETCH1`, `S_LOAD1`, `S_FETCHB`, `S_LOADB`, `S_SEND` and `S_WBACK`.

- `S_FETCH0` issues the read of the descriptor's control word.
- `S_LOAD0` inspects the control word. It goes to `S_FETCH1` if the ready bit is set and to `S_IDLE` if it is not.
- `S_FETCH1` and `S_LOAD1` read the buffer address. From `S_LOAD1` the engine goes to `S_FETCHB`, or straight to `S_WBACK` when the descriptor contributes no bytes.
- `S_FETCHB` and `S_LOADB` read one data word, and `S_SEND` then offers its bytes.
- `S_SEND` stays in place while bytes remain in the current word. It returns to `S_FETCHB` at a word boundary and moves to `S_WBACK` after the last byte of the buffer.
- `S_WBACK` writes the control word back and pulses the events. It then goes to `S_FETCH0`, or to `S_IDLE` when the per-start limit is reached.
- `S_IDLE` moves to `S_FETCH0` on a start pulse while the controller is enabled.
- Clearing `ctl_enable` sends every state to `S_IDLE`.

Top module: `txr_engine`

## Requirements
- R1: After reset the engine is idle. `tx_busy`, `m_tvalid`, `mem_en` and all three event outputs are low.
- R2: While `ctl_enable` is low, a start pulse has no effect: nothing is read, nothing is streamed and memory is left unchanged. Dropping `ctl_enable` aborts any walk by the next cycle and reloads the descriptor pointer from `ring_base`.
- R3: A walk stops at the first descriptor whose ready bit (bit 31 of its first word) is clear. `tx_busy` is low again once the walk has ended.
- R4: A single start processes at most `MAX_DESC` descriptors. The next start resumes at the following descriptor.
- R5: The bytes of each buffer are streamed in increasing address order. The length comes from bits 15:0 of the first word and the byte address from the second word. Byte address A is held in word A/4 at bits 8*(A mod 4)+7 down to 8*(A mod 4), and a buffer may start at any alignment.
- R6: Bit 27 of the first word marks the last buffer of a frame. `m_tlast` is set on the final byte taken from such a buffer, `ev_frame_done` pulses when it is finished, and the frame byte count restarts at zero. A last buffer that contributes no bytes gives no `m_tlast` beat. The byte count also restarts at every start.
- R7: `ev_buf_done` pulses once for every descriptor processed, whether or not it is the last of its frame.
- R8: When the bytes already taken plus the buffer length exceed `MAX_FRAME`, only the bytes that still fit are sent, and `ev_babble` pulses for that descriptor.
- R9: Each processed descriptor has its first word written back with bit 31 cleared and every other bit unchanged. The second word is not written.
- R10: When bit 29 of the first word is set, the next descriptor is read from `ring_base`. Otherwise it is read from the current address plus 8.
- R11: The descriptor pointer is kept from one start to the next.
- R12: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Controller enable; low aborts and reloads the pointer |
| tx_kick | input | 1 | Start pulse |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read; data on `mem_rdata` one cycle later) |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Stream sink ready |
| m_tlast | output | 1 | Final byte of a frame |
| ev_buf_done | output | 1 | Pulse per processed descriptor |
| ev_frame_done | output | 1 | Pulse when a last-marked descriptor is done |
| ev_babble | output | 1 | Pulse when a buffer was clipped |
| tx_busy | output | 1 | Walk in progress |

## Verification
If the state register or the byte counter goes wrong, it shows up on the stream within a few cycles: a byte from the wrong lane, a missing or extra `m_tlast`, or a frame that is too long. A wrong byte accumulator only shows up on the oversize boundary, as a clip at the wrong byte count. A wrong descriptor pointer shows no symptom until the next walk. It then appears as a walk that starts on the wrong slot, as descriptors written back at the wrong location, or as a wrap that goes to the wrong place. The bench therefore compares every beat, every event count and the whole descriptor region of memory after each start, and chains starts so that the pointer carried from one walk is exercised by the next.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH0,
        S_LOAD0,
        S_FETCH1,
        S_LOAD1,
        S_FETCHB,
        S_LOADB,
        S_SEND,
        S_WBACK
    } txr_state_e;

    // bit positions inside the upper halfword of descriptor word 0
    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;

    localparam int DESC_BYTES = 8;
    localparam int LEN_W      = 16;

endpackage

// File: rtl/txr_lenclip.sv
module txr_lenclip #(
    parameter int LENW      = 16,
    parameter int ACCW      = 11,
    parameter int MAX_FRAME = 2047
) (
    input  logic [ACCW-1:0] acc,
    input  logic [LENW-1:0] len,
    output logic [LENW-1:0] take,
    output logic            clipped
);
    logic [LENW:0] room;

    always_comb begin
        room    = (LENW+1)'(MAX_FRAME) - (LENW+1)'(acc);
        clipped = ({1'b0, len} > room);
        take    = clipped ? room[LENW-1:0] : len;
    end
endmodule

// File: rtl/txr_ptr.sv
module txr_ptr #(
    parameter int AW       = 16,
    parameter int MAX_DESC = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_enable,
    input  logic [AW-1:0] ring_base,
    input  logic          kick_start,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] ptr,
    output logic          limit_hit
);
    localparam int CNTW = $clog2(MAX_DESC + 1);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (!ctl_enable) begin
            ptr <= ring_base;
        end else if (advance) begin
            ptr <= wrap ? ring_base : ptr + AW'(txr_pkg::DESC_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || kick_start) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end

    assign limit_hit = (cnt_q == CNTW'(MAX_DESC - 1));
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
    parameter int AW        = 16,
    parameter int MAX_FRAME = 2047,
    parameter int MAX_DESC  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_enable,
    input  logic          tx_kick,
    input  logic [AW-1:0] ring_base,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-3:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast,
    output logic          ev_buf_done,
    output logic          ev_frame_done,
    output logic          ev_babble,
    output logic          tx_busy
);
    import txr_pkg::*;

    localparam int WAW  = AW - 2;
    localparam int LENW = LEN_W;
    localparam int ACCW = $clog2(MAX_FRAME + 1);

    txr_state_e state_q, state_d;

    logic [LENW-1:0] len_q;
    logic [15:0]     flags_q;
    logic [LENW-1:0] rem_q;
    logic [AW-1:0]   baddr_q;
    logic [31:0]     word_q;
    logic [ACCW-1:0] acc_q;
    logic            babble_q;

    logic [LENW-1:0] take;
    logic            clipped;
    logic [AW-1:0]   ptr;
    logic            limit_hit;
    logic            kick_start;
    logic            beat;

    assign kick_start = (state_q == S_IDLE) && tx_kick && ctl_enable;
    assign beat       = (state_q == S_SEND) && m_tready;

    txr_lenclip #(.LENW(LENW), .ACCW(ACCW), .MAX_FRAME(MAX_FRAME)) u_clip (
        .acc     (acc_q),
        .len     (mem_rdata[LENW-1:0]),
        .take    (take),
        .clipped (clipped)
    );

    txr_ptr #(.AW(AW), .MAX_DESC(MAX_DESC)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_enable (ctl_enable),
        .ring_base  (ring_base),
        .kick_start (kick_start),
        .advance    (state_q == S_WBACK),
        .wrap       (flags_q[FLG_WRAP]),
        .ptr        (ptr),
        .limit_hit  (limit_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (kick_start) state_d = S_FETCH0;
            S_FETCH0: state_d = S_LOAD0;
            S_LOAD0:  state_d = mem_rdata[16+FLG_READY] ? S_FETCH1 : S_IDLE;
            S_FETCH1: state_d = S_LOAD1;
            S_LOAD1:  state_d = (rem_q == '0) ? S_WBACK : S_FETCHB;
            S_FETCHB: state_d = S_LOADB;
            S_LOADB:  state_d = S_SEND;
            S_SEND: begin
                if (m_tready) begin
                    if (rem_q == LENW'(1))       state_d = S_WBACK;
                    else if (baddr_q[1:0] == 2'd3) state_d = S_FETCHB;
                end
            end
            S_WBACK:  state_d = limit_hit ? S_IDLE : S_FETCH0;
            default:  state_d = S_IDLE;
        endcase
        if (!ctl_enable) state_d = S_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            flags_q  <= '0;
            rem_q    <= '0;
            baddr_q  <= '0;
            word_q   <= '0;
            acc_q    <= '0;
            babble_q <= 1'b0;
        end else begin
            if (kick_start) acc_q <= '0;
            if (state_q == S_LOAD0 && mem_rdata[16+FLG_READY]) begin
                len_q    <= mem_rdata[LENW-1:0];
                flags_q  <= mem_rdata[31:16];
                rem_q    <= take;
                babble_q <= clipped;
                acc_q    <= mem_rdata[16+FLG_LAST] ? '0 : acc_q + ACCW'(take);
            end
            if (state_q == S_LOAD1) baddr_q <= mem_rdata[AW-1:0];
            if (state_q == S_LOADB) word_q  <= mem_rdata;
            if (beat) begin
                baddr_q <= baddr_q + AW'(1);
                rem_q   <= rem_q - LENW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_en        = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = ptr[AW-1:2];
        mem_wdata     = '0;
        m_tvalid      = 1'b0;
        m_tlast       = 1'b0;
        m_tdata       = word_q[{baddr_q[1:0], 3'b000} +: 8];
        ev_buf_done   = 1'b0;
        ev_frame_done = 1'b0;
        ev_babble     = 1'b0;
        tx_busy       = (state_q != S_IDLE);
        unique case (state_q)
            S_FETCH0: mem_en = 1'b1;
            S_FETCH1: begin
                mem_en   = 1'b1;
                mem_addr = ptr[AW-1:2] + WAW'(1);
            end
            S_FETCHB: begin
                mem_en   = 1'b1;
                mem_addr = baddr_q[AW-1:2];
            end
            S_SEND: begin
                m_tvalid = 1'b1;
                m_tlast  = flags_q[FLG_LAST] && (rem_q == LENW'(1));
            end
            S_WBACK: begin
                mem_en        = 1'b1;
                mem_we        = 1'b1;
                mem_wdata     = {flags_q & ~(16'd1 << FLG_READY), len_q};
                ev_buf_done   = 1'b1;
                ev_frame_done = flags_q[FLG_LAST];
                ev_babble     = babble_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
    parameter int MAX_DESC = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_enable,
    input logic       tx_busy,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic [7:0] m_tdata,
    input logic       m_tlast,
    input logic       ev_buf_done,
    input logic       ev_frame_done,
    input logic       mem_we
);
    localparam int CW = $clog2(MAX_DESC + 2);

    logic [CW-1:0] bufs_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_busy)  bufs_q <= '0;
        else if (ev_buf_done)    bufs_q <= bufs_q + CW'(1);
    end

    a_r2_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !tx_busy);

    a_r4_desc_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bufs_q) <= MAX_DESC);

    a_r6_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    a_r7_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_done |-> ev_buf_done);

    a_r9_wb_not_streaming: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !m_tvalid);

    a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && ctl_enable) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

bind txr_engine txr_engine_chk #(.MAX_DESC(MAX_DESC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_enable    (ctl_enable),
    .tx_busy       (tx_busy),
    .m_tvalid      (m_tvalid),
    .m_tready      (m_tready),
    .m_tdata       (m_tdata),
    .m_tlast       (m_tlast),
    .ev_buf_done   (ev_buf_done),
    .ev_frame_done (ev_frame_done),
    .mem_we        (mem_we)
);

// File: tb/txr_engine_tb.sv
module txr_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int MAXF = 48;
    localparam int MAXD = 4;
    localparam int RB   = 'h100;
    localparam int BUFB = 'h400;
    localparam int NW   = 1 << (AW - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_enable = 1'b0;
    logic tx_kick = 1'b0;
    logic [AW-1:0] ring_base = AW'(RB);
    logic mem_en, mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0] m_tdata;
    logic m_tvalid, m_tlast;
    logic m_tready = 1'b0;
    logic ev_buf_done, ev_frame_done, ev_babble, tx_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    txr_engine #(.AW(AW), .MAX_FRAME(MAXF), .MAX_DESC(MAXD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .tx_kick(tx_kick),
        .ring_base(ring_base), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .ev_buf_done(ev_buf_done),
        .ev_frame_done(ev_frame_done), .ev_babble(ev_babble), .tx_busy(tx_busy)
    );

    logic [31:0] mem [0:NW-1];
    logic [31:0] exp_mem [0:NW-1];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int checks = 0, fails = 0;
    int got_b[$]; bit got_l[$];
    int exp_b[$]; bit exp_l[$];
    int got_buf, got_frame, got_bab, busy_seen;
    int exp_buf, exp_frame, exp_bab;
    int mptr;
    int tready_pct = 70;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // stream sink and event monitor
    initial begin
        forever begin
            @(negedge clk);
            m_tready = (int'($urandom % 100) < tready_pct);
            #1;
            if (rst_n) begin
                if (m_tvalid && m_tready) begin
                    got_b.push_back(int'(m_tdata));
                    got_l.push_back(m_tlast);
                end
                if (ev_buf_done)   got_buf++;
                if (ev_frame_done) got_frame++;
                if (ev_babble)     got_bab++;
                if (tx_busy)       busy_seen++;
            end
        end
    end

    function automatic int getb(int a);
        return int'(mem[a >> 2][8*(a % 4) +: 8]);
    endfunction

    task automatic setb(int a, int v);
        mem[a >> 2][8*(a % 4) +: 8] = 8'(v);
    endtask

    task automatic clear_ring();
        for (int s = 0; s < 8; s++) begin
            mem[(RB + 8*s) >> 2]     = 32'h0;
            mem[(RB + 8*s) >> 2 + 1] = 32'h0;
        end
    endtask

    // place a descriptor k slots after the model pointer
    task automatic place(int k, int len, bit last, int off);
        int s = ((mptr - RB) / 8 + k) % 8;
        int ba = BUFB + s*32 + off;
        logic [31:0] w = 32'(len);
        w[31] = 1'b1;
        w[29] = (s == 7);
        w[27] = last;
        w[26] = $urandom % 2;
        w[24] = $urandom % 2;
        mem[(RB + 8*s) >> 2]     = w;
        mem[((RB + 8*s) >> 2) + 1] = 32'(ba);
        for (int i = 0; i < len; i++) setb(ba + i, int'($urandom % 256));
    endtask

    task automatic model_kick();
        int acc = 0;
        for (int i = 0; i < NW; i++) exp_mem[i] = mem[i];
        exp_b.delete(); exp_l.delete();
        exp_buf = 0; exp_frame = 0; exp_bab = 0;
        for (int n = 0; n < MAXD; n++) begin
            logic [31:0] w0 = exp_mem[mptr >> 2];
            int len, ba, take;
            if (!w0[31]) break;
            len = int'(w0[15:0]);
            ba  = int'(exp_mem[(mptr >> 2) + 1]);
            take = len;
            if (acc + len > MAXF) begin
                take = MAXF - acc;
                exp_bab++;
            end
            for (int i = 0; i < take; i++) begin
                exp_b.push_back(getb(ba + i));
                exp_l.push_back(w0[27] && (i == take - 1));
            end
            acc += take;
            if (w0[27]) begin acc = 0; exp_frame++; end
            exp_buf++;
            w0[31] = 1'b0;
            exp_mem[mptr >> 2] = w0;
            mptr = w0[29] ? RB : mptr + 8;
        end
    endtask

    task automatic wait_idle(string req);
        int t = 0;
        while (t < 20000) begin
            @(negedge clk);
            if (!tx_busy) break;
            t++;
        end
        if (t >= 20000) chk(1'b0, req, "walk timeout", t, 0);
        @(negedge clk); #2;
    endtask

    task automatic pulse_kick();
        @(negedge clk); tx_kick = 1'b1;
        @(negedge clk); tx_kick = 1'b0;
    endtask

    task automatic run_kick(string req);
        int n, bad;
        got_b.delete(); got_l.delete();
        got_buf = 0; got_frame = 0; got_bab = 0;
        model_kick();
        pulse_kick();
        wait_idle(req);
        chk(got_b.size() == exp_b.size(), req, "beat count", got_b.size(), exp_b.size());
        n = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
        for (int i = 0; i < n; i++) begin
            chk(got_b[i] == exp_b[i], "R5", "byte", got_b[i], exp_b[i]);
            chk(got_l[i] == exp_l[i], "R6", "tlast", int'(got_l[i]), int'(exp_l[i]));
        end
        chk(got_buf == exp_buf, "R7", "buffer events", got_buf, exp_buf);
        chk(got_frame == exp_frame, "R6", "frame events", got_frame, exp_frame);
        chk(got_bab == exp_bab, "R8", "babble events", got_bab, exp_bab);
        bad = 0;
        for (int i = RB >> 2; i < (RB >> 2) + 16; i++)
            if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, "R9", "descriptor words differing", bad, 0);
        chk(!tx_busy, "R3", "busy after walk", int'(tx_busy), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NW; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        #2;
        chk(!tx_busy && !m_tvalid && !mem_en, "R1", "idle outputs", int'({tx_busy, m_tvalid, mem_en}), 0);
        chk(!ev_buf_done && !ev_frame_done && !ev_babble, "R1", "events", int'({ev_buf_done, ev_frame_done, ev_babble}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mptr = RB;
        clear_ring();

        // R2: start while disabled
        place(0, 5, 1'b1, 1);
        busy_seen = 0; got_b.delete();
        pulse_kick();
        repeat (10) @(negedge clk);
        chk(busy_seen == 0, "R2", "busy cycles while disabled", busy_seen, 0);
        chk(got_b.size() == 0, "R2", "beats while disabled", got_b.size(), 0);
        chk(mem[RB >> 2][31] == 1'b1, "R2", "ready bit untouched", int'(mem[RB >> 2][31]), 1);

        ctl_enable = 1'b1;
        @(negedge clk);
        run_kick("R5");                       // single buffer frame
        place(0, 7, 1'b0, 3); place(1, 1, 1'b0, 2); place(2, 9, 1'b1, 0);
        run_kick("R6");                       // three-buffer frame
        place(0, 30, 1'b0, 0); place(1, 25, 1'b1, 1);
        run_kick("R8");                       // clip on the last buffer
        place(0, 4, 1'b1, 2); place(1, 6, 1'b1, 3);
        run_kick("R10");                      // slots 6 and 7, wrap
        chk(mptr == RB, "R10", "model pointer at base", mptr, RB);
        place(0, 3, 1'b1, 0);
        run_kick("R10");                      // slot 0 after the wrap
        for (int k = 0; k < 6; k++) place(k, 2 + k, 1'b1, k % 4);
        run_kick("R4");                       // stops at the limit
        chk(got_buf == MAXD, "R4", "descriptors in one start", got_buf, MAXD);
        run_kick("R11");                      // resumes where it stopped
        place(0, 48, 1'b0, 0); place(1, 5, 1'b1, 0);
        run_kick("R6");                       // last buffer contributes nothing
        run_kick("R3");                       // nothing ready
        chk(got_b.size() == 0, "R3", "beats on empty ring", got_b.size(), 0);

        // R2: disabling reloads the pointer
        ctl_enable = 1'b0;
        repeat (2) @(negedge clk);
        ctl_enable = 1'b1;
        mptr = RB;
        clear_ring();
        place(0, 6, 1'b1, 1);
        run_kick("R2");

        // random rounds, including fully stalled sink phases
        for (int r = 0; r < 40; r++) begin
            int k = 0;
            int nf = 1 + int'($urandom % 3);
            clear_ring();
            tready_pct = (r % 5 == 0) ? 20 : 75;
            for (int f = 0; f < nf && k < 7; f++) begin
                int nb = 1 + int'($urandom % 3);
                for (int b = 0; b < nb && k < 7; b++) begin
                    place(k, 1 + int'($urandom % 28), (b == nb - 1) || (k == 6), int'($urandom % 4));
                    k++;
                end
            end
            run_kick("R5");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule